// File: doc/BRIEF.md
# Orthogonal Bit Tile Rotator

This block turns a square tile of one-bit pixels on its side, so that a display path can rotate a bitonal page by a quarter turn in either direction. The host writes the tile one scan line at a time: each write carries the byte found at the same horizontal position on successive lines. Once the last line of the tile is in, the host reads the tile back. Each read returns a byte built from one bit of every stored line. The read also advances all line registers at once, so the next read sees the next pixel column.

There is no addressed storage. Each line sits in its own shift register. Reads advance the registers from the most significant end for a clockwise turn and from the least significant end for an anticlockwise turn. The line order in the output byte is mirrored between the two turns. Data that needs no rotation never enters the block. An access made in the wrong phase is discarded and reported on a one-cycle error pulse.

Top module: `tile_rotator`

## Requirements
- R1: After reset, `tileReady`, `tileBusy` and `accessErr` are all 0.
- R2: While loading, the k-th accepted write (k = 0 to N-1) stores `wrData` as line k. In the cycle after the N-th write, `tileReady` is 1 and writes stop being accepted.
- R3: `tileBusy` is 1 from the cycle after the first write of a tile until the last read of that tile has been taken, and 0 otherwise.
- R4: With `dirSel`=0 (clockwise), read number k (k = 0 to N-1) returns a byte whose bit i equals bit N-1-k of line i.
- R5: With `dirSel`=1 (anticlockwise), read number k returns a byte whose bit i equals bit k of line N-1-i.
- R6: Each accepted read advances every line by one bit. After N reads `tileReady` returns to 0 in the next cycle, and the next tile loads from line 0.
- R7: A write while `tileReady` is 1 changes no stored data and no count, and raises `accessErr` for exactly the following cycle.
- R8: A read while `tileReady` is 0 shifts nothing and counts nothing, and raises `accessErr` for exactly the following cycle. `rdData` is 0 while `tileReady` is 0.
- R9: The direction is taken from `dirSel` on the write that completes a tile. Changes on `dirSel` during draining have no effect on `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one line |
| wrData | input | N | Line byte being written |
| dirSel | input | 1 | 0 = clockwise quarter turn, 1 = anticlockwise |
| rdEn | input | 1 | Read strobe; consumes the current column |
| rdData | output | N | Current rotated column, 0 when no tile is ready |
| tileReady | output | 1 | A full tile is held and can be read |
| tileBusy | output | 1 | A tile is partly loaded or still draining |
| accessErr | output | 1 | One-cycle pulse after an out-of-phase access |

## Verification
The bench loads every tile with a single set pixel, in both directions. A swapped line order, a reversed bit order or a shift in the wrong direction would therefore misplace that one bit in a way that shows directly. Random tiles add dense patterns. The bench flips `dirSel` during every drain, which exposes a design that reads the direction live. It also reads in the middle of a load and writes in the middle of a drain. A design that counted or stored such an access would return a corrupted or shifted tile afterwards, and one that held the error flag would show a stuck pulse.

// File: rtl/tile_rotator_pkg.sv
package tile_rotator_pkg;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } rotPhase_t;

  typedef struct packed {
    logic loadEn;
    logic shiftEn;
    logic dirRev;
  } rotStrobes_t;

endpackage

// File: rtl/tile_rotator_datapath.sv
module tile_rotator_datapath
  import tile_rotator_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  rotStrobes_t      ctl,
  input  logic [IDXW-1:0]  loadIdx,
  input  logic [N-1:0]     wrData,
  input  logic             outValid,
  output logic [N-1:0]     rdData
);

  logic [N-1:0] lineReg [N];

  for (genvar r = 0; r < N; r++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lineReg[r] <= '0;
      end else if (ctl.loadEn && (loadIdx == IDXW'(r))) begin
        lineReg[r] <= wrData;
      end else if (ctl.shiftEn) begin
        if (ctl.dirRev) lineReg[r] <= {1'b0, lineReg[r][N-1:1]};
        else            lineReg[r] <= {lineReg[r][N-2:0], 1'b0};
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : gOut
    always_comb begin
      if (!outValid)       rdData[i] = 1'b0;
      else if (ctl.dirRev) rdData[i] = lineReg[N-1-i][0];
      else                 rdData[i] = lineReg[i][N-1];
    end
  end

  // R6: loading and shifting never coincide
  assert_no_load_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadEn, ctl.shiftEn}));

  // R4: a clockwise shift moves line 0 toward its top end
  assert_shift_fwd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && !ctl.dirRev) |=> (lineReg[0][N-1:1] == $past(lineReg[0][N-2:0])));

  // R5: an anticlockwise shift moves the last line toward its bottom end
  assert_shift_rev_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && ctl.dirRev) |=> (lineReg[N-1][N-2:0] == $past(lineReg[N-1][N-1:1])));

  // R8: no valid tile means the output reads as zero
  assert_quiet_out_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (rdData == '0));

endmodule

// File: rtl/tile_rotator_ctrl.sv
module tile_rotator_ctrl
  import tile_rotator_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             dirSel,
  output rotStrobes_t      ctl,
  output logic [IDXW-1:0]  loadIdx,
  output logic             tileReady,
  output logic             tileBusy,
  output logic             accessErr
);

  rotPhase_t       phase;
  logic [IDXW-1:0] stepCnt;
  logic            dirQ;
  logic            errQ;
  logic            wrOk, rdOk, badAccess, lastStep;

  always_comb begin
    wrOk      = (phase == PH_FILL)  && wrEn;
    rdOk      = (phase == PH_DRAIN) && rdEn;
    badAccess = ((phase == PH_FILL) && rdEn) || ((phase == PH_DRAIN) && wrEn);
    lastStep  = (stepCnt == IDXW'(N - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_FILL;
      stepCnt <= '0;
      dirQ    <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      errQ <= badAccess;
      if (wrOk || rdOk) begin
        stepCnt <= lastStep ? '0 : stepCnt + IDXW'(1);
      end
      if (wrOk && lastStep) begin
        phase <= PH_DRAIN;
        dirQ  <= dirSel;
      end else if (rdOk && lastStep) begin
        phase <= PH_FILL;
      end
    end
  end

  always_comb begin
    ctl.loadEn  = wrOk;
    ctl.shiftEn = rdOk;
    ctl.dirRev  = dirQ;
    loadIdx     = stepCnt;
    tileReady   = (phase == PH_DRAIN);
    tileBusy    = (phase == PH_DRAIN) || (stepCnt != '0);
    accessErr   = errQ;
  end

  // R7: a write during draining is flagged next cycle
  assert_wr_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tileReady && wrEn) |=> accessErr);

  // R8: a read during loading is flagged next cycle
  assert_rd_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!tileReady && rdEn) |=> accessErr);

  // R2: the final write of a tile makes it ready
  assert_fill_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!tileReady && wrEn && lastStep) |=> tileReady);

  // R6: the final read of a tile returns to loading
  assert_drain_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tileReady && rdEn && lastStep) |=> !tileReady);

  // R9: direction holds through draining
  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tileReady && $past(tileReady)) |-> $stable(ctl.dirRev));

  // R3: a ready tile always counts as busy
  assert_busy_cover_R3: assert property (@(posedge clk) disable iff (!rstN)
    tileReady |-> tileBusy);

endmodule

// File: rtl/tile_rotator.sv
module tile_rotator
  import tile_rotator_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [N-1:0] wrData,
  input  logic         dirSel,
  input  logic         rdEn,
  output logic [N-1:0] rdData,
  output logic         tileReady,
  output logic         tileBusy,
  output logic         accessErr
);

  localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1;

  rotStrobes_t     ctl;
  logic [IDXW-1:0] loadIdx;

  tile_rotator_ctrl #(.N(N)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .dirSel    (dirSel),
    .ctl       (ctl),
    .loadIdx   (loadIdx),
    .tileReady (tileReady),
    .tileBusy  (tileBusy),
    .accessErr (accessErr)
  );

  tile_rotator_datapath #(.N(N)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .loadIdx  (loadIdx),
    .wrData   (wrData),
    .outValid (tileReady),
    .rdData   (rdData)
  );

endmodule

// File: tb/tile_rotator_test.sv
`timescale 1ns/1ps
module tile_rotator_test;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [N-1:0] wrData = '0;
  logic         dirSel = 1'b0;
  logic         rdEn = 1'b0;
  logic [N-1:0] rdData;
  logic         tileReady, tileBusy, accessErr;

  int total = 0;
  int bad = 0;
  logic [N-1:0] tile [N];

  always #5 clk = ~clk;

  tile_rotator #(.N(N)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .dirSel(dirSel),
    .rdEn(rdEn), .rdData(rdData), .tileReady(tileReady), .tileBusy(tileBusy),
    .accessErr(accessErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] expCol(input int k, input logic rev);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = rev ? tile[N-1-i][k] : tile[i][N-1-k];
    return v;
  endfunction

  task automatic doWrite(input logic [N-1:0] d, input logic dir);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; dirSel = dir;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input int k, input logic rev);
    @(negedge clk);
    rdEn = 1'b1;
    dirSel = ~rev;  // R9: flipping the select while draining must not matter
    #1;
    chk(rev ? "R5 column" : "R4 column", rdData, expCol(k, rev));
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic loadTile(input logic rev);
    for (int j = 0; j < N; j++) begin
      doWrite(tile[j], rev);
      if (j < N-1) begin
        chk("R3 busy during load", tileBusy, 1'b1);
        chk("R2 not ready early", tileReady, 1'b0);
      end
    end
    chk("R2 ready after last line", tileReady, 1'b1);
  endtask

  task automatic drainTile(input logic rev);
    for (int k = 0; k < N; k++) doRead(k, rev);
    chk("R6 ready drops after drain", tileReady, 1'b0);
    chk("R3 idle after drain", tileBusy, 1'b0);
  endtask

  initial begin : watchdog
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready at reset", tileReady, 1'b0);
    chk("R1 busy at reset", tileBusy, 1'b0);
    chk("R1 err at reset", accessErr, 1'b0);
    chk("R8 output zero at reset", rdData, '0);
    rstN = 1'b1;

    // single-pixel sweep in both directions (R4, R5, R6)
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < N*N; p++) begin
        for (int j = 0; j < N; j++) tile[j] = '0;
        tile[p / N][p % N] = 1'b1;
        loadTile(d[0]);
        drainTile(d[0]);
      end
    end

    // dense random tiles
    for (int t = 0; t < 40; t++) begin
      for (int j = 0; j < N; j++) tile[j] = N'($urandom);
      loadTile(t[0]);
      drainTile(t[0]);
    end

    // R8: a read in the middle of a load is ignored and flagged
    for (int j = 0; j < N; j++) tile[j] = N'($urandom);
    for (int j = 0; j < 3; j++) doWrite(tile[j], 1'b0);
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    chk("R8 err pulse", accessErr, 1'b1);
    chk("R8 still loading", tileReady, 1'b0);
    @(negedge clk);
    chk("R8 err one cycle", accessErr, 1'b0);
    for (int j = 3; j < N; j++) doWrite(tile[j], 1'b0);
    chk("R8 ready after real writes", tileReady, 1'b1);
    drainTile(1'b0);

    // R7: a write in the middle of a drain is ignored and flagged
    for (int j = 0; j < N; j++) tile[j] = N'($urandom);
    loadTile(1'b1);
    doRead(0, 1'b1);
    doRead(1, 1'b1);
    doWrite(N'($urandom), 1'b0);
    chk("R7 err pulse", accessErr, 1'b1);
    chk("R7 still ready", tileReady, 1'b1);
    @(negedge clk);
    chk("R7 err one cycle", accessErr, 1'b0);
    for (int k = 2; k < N; k++) doRead(k, 1'b1);
    chk("R7 drain ends on time", tileReady, 1'b0);

    // R6: the next tile starts at line 0
    for (int j = 0; j < N; j++) tile[j] = N'(j * 37 + 5);
    loadTile(1'b0);
    drainTile(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule